// File: doc/BRIEF.md
# Overcurrent and Undervoltage Fault Supervisor

This block sits between the gate-drive command path and the deadtime generator of a three-leg bridge driver. It receives a digitized overcurrent comparator bit, an undervoltage status bit for the low-side supply and one undervoltage bit for each of the three floating high-side supplies. It drives a global shutdown line that forces all six gate outputs off, an active-low fault line that models the enable of an open-drain pull-down, and a per-leg high-side disable.

A trip is ignored during a blanking window that opens on every edge seen on the six gate feedback bits, so that switching transients cannot cause a trip. A trip outside the window, or a low-side undervoltage, latches the fault. The fault is released only after the command inputs have stayed inactive for a programmable clear time. A build parameter chooses whether only the low-side commands, or both the low-side and the high-side commands, must be quiet.

The controller has four states. ST_UVLO is entered from reset and from any state whenever the low-side supply is reported low. Its exit is *supply-good*, which leads to ST_LATCH. ST_RUN is the only state with outputs enabled. Its *trip* transition leads to ST_LATCH. ST_LATCH leaves by *quiet* (commands inactive and no trip) into ST_CLEAR. ST_CLEAR leaves by *retrip* or *command-active* back to ST_LATCH, or by *timer-expired* into ST_RUN.

Top module: `fault_supervisor`

## Requirements
- R1: During and after reset the block is in ST_UVLO: `fault_n`=0, `shutdown`=1 and all `hs_off` bits are 1.
- R2: When `lv_uv` is sampled 1, the next cycle shows `fault_n`=0 and `shutdown`=1. This holds for as long as `lv_uv` stays 1, however long the commands are quiet. When `lv_uv` returns to 0 the block moves to ST_LATCH and still needs the full clear sequence of R6.
- R3: `trip_in` passes a two-flop synchronizer. If it is outside blanking, the fault (`fault_n`=0, `shutdown`=1, every `hs_off` bit 1) becomes visible in the cycle after the second rising edge following the edge that first samples `trip_in`=1.
- R4: Any change on the 6-bit `gate_fb` opens a blanking window. A trip is ignored on the edge that samples the change and on the following BLANK_CYC edges. A further change inside the window restarts it, including a change sampled on the very edge on which the window would have closed.
- R5: In ST_CLEAR, a command bit returning to 1 restarts the clear count from zero, and a qualified trip re-latches the fault at once.
- R6: In ST_LATCH, the fault is released on the (CLR_CYC+2)-th consecutive rising edge that samples the commands quiet while the synchronized trip is 0. A command bit of 1 means "switch on".
- R7: With CLR_HS=0 only `cmd_lo` must be all zero to count as quiet. With CLR_HS=1, `cmd_lo` and `cmd_hi` must both be all zero.
- R8: `hs_uv[i]`=1 forces `hs_off[i]`=1 in the same cycle. It has no effect on `fault_n`, on `shutdown` or on the other legs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trip_in | input | 1 | Digitized overcurrent comparator output, asynchronous |
| lv_uv | input | 1 | Low-side supply undervoltage, 1 = low |
| hs_uv | input | LEGS | Per-leg floating supply undervoltage, 1 = low |
| cmd_hi | input | LEGS | High-side switch commands, 1 = on |
| cmd_lo | input | LEGS | Low-side switch commands, 1 = on |
| gate_fb | input | 2*LEGS | Filtered gate output states, used for blanking |
| shutdown | output | 1 | Force all six gate outputs off |
| fault_n | output | 1 | Fault indication, 0 = pull-down enabled |
| hs_off | output | LEGS | Per-leg high-side disable |

## Verification
The two functions that can land on one cycle are the end of a blanking window and the restart of that window by a new gate edge, while a held trip waits to be confirmed. The bench raises the trip together with a gate change. It then changes `gate_fb` again so that the new change is sampled on exactly the edge on which the first window would have released the trip. The expected result is no fault on that edge and a fault exactly one full window later. A scoreboard entry is placed on each of those cycles.

// File: rtl/fsv_pkg.sv
`timescale 1ns/1ps
package fsv_pkg;

    typedef enum logic [1:0] {
        ST_UVLO  = 2'd0,
        ST_RUN   = 2'd1,
        ST_LATCH = 2'd2,
        ST_CLEAR = 2'd3
    } fsv_state_t;

endpackage

// File: rtl/fsv_trip_qual.sv
`timescale 1ns/1ps
module fsv_trip_qual #(
    parameter int BLANK_CYC   = 100,
    parameter int NGATE       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trip_in,
    input  logic [NGATE-1:0] gate_fb,
    output logic             trip_sync,
    output logic             trip_ok,
    output logic             blanking
);

    localparam int BW = $clog2(BLANK_CYC + 1);
    localparam logic [BW-1:0] BLANK_LOAD = BW'(BLANK_CYC);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [NGATE-1:0]       gate_q;
    logic [BW-1:0]          blank_cnt;
    logic                   gate_chg;

    // metastability chain for the asynchronous comparator bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], trip_in};
        end
    end

    assign trip_sync = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_fb;
        end
    end

    assign gate_chg = |(gate_fb ^ gate_q);

    // window reloads on every gate edge, counts down otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blank_cnt <= '0;
        end else if (gate_chg) begin
            blank_cnt <= BLANK_LOAD;
        end else if (blank_cnt != '0) begin
            blank_cnt <= blank_cnt - 1'b1;
        end
    end

    assign blanking = gate_chg || (blank_cnt != '0);
    assign trip_ok  = trip_sync && !blanking;

    // R3: a qualified trip always stems from the pin two edges earlier
    p_trip_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trip_ok |-> $past(trip_in, 2));

    // R4: a gate edge leaves the window open on the following cycle
    p_window_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gate_chg |=> !trip_ok);

endmodule

// File: rtl/fsv_clear_timer.sv
`timescale 1ns/1ps
module fsv_clear_timer #(
    parameter int CLR_CYC = 2125,
    parameter int LEGS    = 3,
    parameter bit CLR_HS  = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic [LEGS-1:0] cmd_lo,
    input  logic [LEGS-1:0] cmd_hi,
    output logic            idle,
    output logic            done
);

    localparam int CW = $clog2(CLR_CYC + 1);
    localparam logic [CW-1:0] CNT_END = CW'(CLR_CYC);

    logic          lo_quiet;
    logic          hs_quiet;
    logic [CW-1:0] cnt;

    assign lo_quiet = ~|cmd_lo;
    assign hs_quiet = ~|cmd_hi;
    // R7: build parameter selects whether high-side commands gate the clear
    assign idle     = lo_quiet && (hs_quiet || !CLR_HS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (arm && idle) begin
            if (cnt != CNT_END) begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt <= '0;
        end
    end

    assign done = (cnt == CNT_END);

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_END);

    // R5: an active command observed while armed leaves the count at zero
    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !lo_quiet) |=> !done);

endmodule

// File: rtl/fsv_fault_fsm.sv
`timescale 1ns/1ps
module fsv_fault_fsm
    import fsv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lv_uv,
    input  logic       trip_ok,
    input  logic       trip_sync,
    input  logic       idle,
    input  logic       done,
    output fsv_state_t state,
    output logic       shutdown,
    output logic       fault_n
);

    fsv_state_t nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_UVLO;
        end else begin
            state <= nxt;
        end
    end

    // transitions; low-side undervoltage has top priority
    always_comb begin
        nxt = state;
        unique case (state)
            ST_UVLO: begin
                if (!lv_uv) nxt = ST_LATCH;               // supply-good
            end
            ST_RUN: begin
                if (lv_uv)        nxt = ST_UVLO;
                else if (trip_ok) nxt = ST_LATCH;         // trip
            end
            ST_LATCH: begin
                if (lv_uv)                      nxt = ST_UVLO;
                else if (idle && !trip_sync)    nxt = ST_CLEAR;   // quiet
            end
            ST_CLEAR: begin
                if (lv_uv)                      nxt = ST_UVLO;
                else if (trip_sync || trip_ok)  nxt = ST_LATCH;   // retrip
                else if (!idle)                 nxt = ST_LATCH;   // command-active
                else if (done)                  nxt = ST_RUN;     // timer-expired
            end
            default: nxt = ST_UVLO;
        endcase
    end

    // outputs
    always_comb begin
        shutdown = 1'b1;
        fault_n  = 1'b0;
        unique case (state)
            ST_RUN: begin
                shutdown = 1'b0;
                fault_n  = 1'b1;
            end
            ST_UVLO, ST_LATCH, ST_CLEAR: begin
                shutdown = 1'b1;
                fault_n  = 1'b0;
            end
            default: begin
                shutdown = 1'b1;
                fault_n  = 1'b0;
            end
        endcase
    end

    p_uv_forces_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lv_uv |=> (!fault_n && shutdown));

    p_trip_shuts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && trip_ok) |=> shutdown);

    p_no_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR && (trip_ok || !idle)) |=> state != ST_RUN);

    p_release_needs_timer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_n) |-> ($past(done) && $past(idle)));

endmodule

// File: rtl/fault_supervisor.sv
`timescale 1ns/1ps
module fault_supervisor
    import fsv_pkg::*;
#(
    parameter int BLANK_CYC = 100,
    parameter int CLR_CYC   = 2125,
    parameter int LEGS      = 3,
    parameter bit CLR_HS    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trip_in,
    input  logic              lv_uv,
    input  logic [LEGS-1:0]   hs_uv,
    input  logic [LEGS-1:0]   cmd_hi,
    input  logic [LEGS-1:0]   cmd_lo,
    input  logic [2*LEGS-1:0] gate_fb,
    output logic              shutdown,
    output logic              fault_n,
    output logic [LEGS-1:0]   hs_off
);

    localparam int NGATE = 2 * LEGS;

    logic       trip_sync;
    logic       trip_ok;
    logic       blanking;
    logic       idle;
    logic       done;
    fsv_state_t st;

    fsv_trip_qual #(
        .BLANK_CYC   (BLANK_CYC),
        .NGATE       (NGATE),
        .SYNC_STAGES (2)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .trip_in   (trip_in),
        .gate_fb   (gate_fb),
        .trip_sync (trip_sync),
        .trip_ok   (trip_ok),
        .blanking  (blanking)
    );

    fsv_clear_timer #(
        .CLR_CYC (CLR_CYC),
        .LEGS    (LEGS),
        .CLR_HS  (CLR_HS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (st == ST_CLEAR),
        .cmd_lo (cmd_lo),
        .cmd_hi (cmd_hi),
        .idle   (idle),
        .done   (done)
    );

    fsv_fault_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lv_uv     (lv_uv),
        .trip_ok   (trip_ok),
        .trip_sync (trip_sync),
        .idle      (idle),
        .done      (done),
        .state     (st),
        .shutdown  (shutdown),
        .fault_n   (fault_n)
    );

    // R8: per-leg high-side disable from global shutdown or own supply
    for (genvar i = 0; i < LEGS; i++) begin : g_leg
        assign hs_off[i] = shutdown | hs_uv[i];
    end

    p_blank_masks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && blanking && !lv_uv) |=> st == ST_RUN);

    p_hs_iso_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !shutdown |-> (hs_off == hs_uv));

    p_all_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (&hs_off && !fault_n));

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (shutdown && !fault_n));

endmodule

// File: tb/fault_supervisor_test.sv
`timescale 1ns/1ps
module fault_supervisor_test;

    localparam int B = 8;
    localparam int C = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trip_in = 1'b0;
    logic       lv_uv = 1'b1;
    logic [2:0] hs_uv = '0;
    logic [2:0] cmd_hi = '0;
    logic [2:0] cmd_lo = '0;
    logic [5:0] gate_fb = '0;

    logic       shutdown, fault_n, shutdown_b, fault_n_b;
    logic [2:0] hs_off, hs_off_b;

    int cyc = 0;
    int n_checks = 0;
    int n_fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fault_supervisor #(.BLANK_CYC(B), .CLR_CYC(C), .LEGS(3), .CLR_HS(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .trip_in(trip_in), .lv_uv(lv_uv), .hs_uv(hs_uv),
        .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .gate_fb(gate_fb),
        .shutdown(shutdown), .fault_n(fault_n), .hs_off(hs_off));

    fault_supervisor #(.BLANK_CYC(B), .CLR_CYC(C), .LEGS(3), .CLR_HS(1'b1)) uut_b (
        .clk(clk), .rst_n(rst_n), .trip_in(trip_in), .lv_uv(lv_uv), .hs_uv(hs_uv),
        .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .gate_fb(gate_fb),
        .shutdown(shutdown_b), .fault_n(fault_n_b), .hs_off(hs_off_b));

    // expected vector: {fault_n, shutdown, hs_off[2:0], fault_n of both-quiet variant}
    typedef struct {
        int         at;
        logic [5:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb[$];

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_at(input int d, input logic fn, input logic sd,
                             input logic [2:0] ho, input logic fnb, input string tag);
        sb_item_t it;
        int idx;
        it.at  = cyc + d;
        it.exp = {fn, sd, ho, fnb};
        it.tag = tag;
        idx = sb.size();
        for (int k = 0; k < sb.size(); k++) begin
            if (sb[k].at > it.at) begin
                idx = k;
                break;
            end
        end
        sb.insert(idx, it);
    endtask

    task automatic expect_run(input int d, input string tag);
        expect_at(d, 1'b1, 1'b0, 3'b000, 1'b1, tag);
    endtask

    task automatic expect_flt(input int d, input string tag);
        expect_at(d, 1'b0, 1'b1, 3'b111, 1'b0, tag);
    endtask

    // monitor: compare outputs against scoreboard away from the active edge
    always @(negedge clk) begin
        logic [5:0] got;
        sb_item_t it;
        got = {fault_n, shutdown, hs_off, fault_n_b};
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            it = sb.pop_front();
            n_checks++;
            if (it.at != cyc || got !== it.exp) begin
                n_fails++;
                $display("FAIL %s cycle %0d: got %b expected %b (scheduled %0d)",
                         it.tag, cyc, got, it.exp, it.at);
            end
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        expect_flt(0, "R1 reset state");
        step(2);

        // power-up: supply good, then full clear sequence
        lv_uv = 1'b0;
        expect_flt(1, "R2 latched after supply good");
        expect_flt(C + 2, "R6 still held before clear time");
        expect_run(C + 3, "R6 release after clear time");
        step(C + 6);

        // floating supply undervoltage affects only its leg
        hs_uv = 3'b010;
        expect_at(0, 1'b1, 1'b0, 3'b010, 1'b1, "R8 leg 1 disabled alone");
        step(2);
        hs_uv = 3'b000;
        expect_run(0, "R8 leg re-enabled");
        step(2);

        // trip outside blanking, then clear with a restart
        trip_in = 1'b1;
        cmd_lo  = 3'b001;
        expect_run(2, "R3 not yet confirmed");
        expect_flt(3, "R3 all outputs off");
        step(5);
        trip_in = 1'b0;
        step(5);
        cmd_lo = 3'b000;
        step(10);
        cmd_lo = 3'b100;
        step(1);
        cmd_lo = 3'b000;
        expect_flt(C - 9, "R5 command restart delays clear");
        expect_flt(C + 1, "R6 held one edge before release");
        expect_run(C + 2, "R6 release after restart");
        step(C + 5);

        // clear rule variant: high-side command still active
        trip_in = 1'b1;
        cmd_hi  = 3'b010;
        step(4);
        trip_in = 1'b0;
        expect_flt(C + 3, "R7 both variants held");
        expect_at(C + 4, 1'b1, 1'b0, 3'b000, 1'b0, "R7 low-only clears, both-quiet held");
        step(C + 8);
        cmd_hi = 3'b000;
        expect_at(C + 1, 1'b1, 1'b0, 3'b000, 1'b0, "R7 both-quiet still counting");
        expect_run(C + 2, "R7 both-quiet released");
        step(C + 5);

        // new trip during clear interval
        trip_in = 1'b1;
        step(4);
        trip_in = 1'b0;
        step(6);
        trip_in = 1'b1;
        expect_flt(C - 2, "R5 retrip cancels pending release");
        step(C);
        trip_in = 1'b0;
        expect_flt(C + 3, "R6 held before release after retrip");
        expect_run(C + 4, "R6 release after retrip");
        step(C + 8);

        // short trip inside blanking window
        gate_fb = 6'h01;
        trip_in = 1'b1;
        step(4);
        trip_in = 1'b0;
        expect_run(6, "R4 short trip masked");
        step(12);

        // window expiry and restart on the same edge
        gate_fb = 6'h03;
        trip_in = 1'b1;
        step(B + 1);
        gate_fb = 6'h07;
        expect_run(1, "R4 restart on expiry edge masks trip");
        expect_run(B + 1, "R4 still blanked by second window");
        expect_flt(B + 2, "R4 trip taken after second window");
        step(B + 5);
        trip_in = 1'b0;
        expect_run(C + 4, "R6 release after blanked trip");
        step(C + 6);

        // low-side undervoltage while running
        lv_uv = 1'b1;
        expect_run(0, "R2 before undervoltage sampled");
        expect_flt(1, "R2 undervoltage faults");
        step(C + 10);
        expect_flt(0, "R2 held beyond clear time");
        lv_uv = 1'b0;
        expect_flt(1, "R2 exit goes to latched state");
        expect_flt(C + 2, "R6 held after undervoltage");
        expect_run(C + 3, "R6 release after undervoltage");
        step(C + 6);

        wait (sb.size() == 0);
        step(2);
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule